// File: doc/BRIEF.md
# Single-Instruction Subtract-and-Branch Processor

This block is a processor core with one instruction only. Each instruction subtracts one memory byte from another, stores the difference in place of the minuend, and jumps when the stored difference is negative. An instruction is six bytes long and holds three 16-bit addresses: the subtrahend location B, the minuend location A, and the jump target C. Each address is stored low byte first.

The core drives a 16-bit byte address and talks to a byte-wide synchronous memory. A read strobe in one cycle returns the byte in the next cycle, and a write strobe commits the byte at the clock edge. A micro-step sequencer builds each operand address in a two-byte pointer, one byte per fetch. It latches B, forms A minus B in a result latch and writes that result back. It then either loads the pointer into the program counter or steps past the target bytes with two single increments. A one-cycle done pulse marks the end of every instruction. The program counter is visible on a port, so an instruction stream can be traced.

Top module: `negbranch_cpu`

## Requirements
- R1: While rst_n is low, pc is 0x0000, mem_wr_en is 0, and mem_rd_en is 1 with mem_addr 0x0000, so the first fetch comes from address zero.
- R2: An operand address is built from two consecutive bytes, the byte at the lower address being bits 7:0 and the next byte bits 15:8; the operand read is issued at exactly that 16-bit address.
- R3: The written byte equals (byte at A minus byte at B) modulo 256, with the borrow dropped, and it is written to the A address.
- R4: mem_wr_en is high for exactly one cycle in each instruction.
- R5: When bit 7 of the result is 1, pc after the instruction equals the C address, assembled low byte first from instruction bytes 4 and 5.
- R6: When bit 7 of the result is 0 (zero included), pc after the instruction equals the instruction start plus 6.
- R7: instr_done is high for one cycle per instruction, and in the following cycle pc already holds the next instruction's start address.
- R8: mem_rd_en and mem_wr_en are never high in the same cycle.
- R9: Per instruction the read strobes address, in order: PC, PC+1, B address, PC+2, PC+3, A address, and only when the jump is taken PC+4, PC+5; read data is taken in the cycle after each strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 16 | Byte address for reads and writes |
| mem_rd_en | output | 1 | Read strobe, data expected next cycle |
| mem_rdata | input | 8 | Read data, one cycle after the strobe |
| mem_wr_en | output | 1 | Write strobe for mem_wdata at mem_addr |
| mem_wdata | output | 8 | Byte to write (the result latch) |
| instr_done | output | 1 | One-cycle pulse at the end of each instruction |
| pc | output | 16 | Program counter |

## Verification
A wrong pointer byte or a wrong program counter shows within a few cycles as a read strobe at an unexpected address, because every instruction byte and operand is fetched through mem_addr. A wrong B latch or subtractor shows at the single write strobe of that instruction, as a wrong byte or address. A wrong branch decision is visible in pc one cycle after the done pulse, and also as missing or extra reads of the target bytes. A damaged sequence normally shows as a surplus or missing strobe before the next done pulse.

// File: rtl/negbr_pkg.sv
package negbr_pkg;

   typedef enum logic [4:0] {
      ST_BLO_RQ, ST_BLO_CP, ST_BHI_RQ, ST_BHI_CP, ST_BOP_RQ, ST_BOP_CP,
      ST_ALO_RQ, ST_ALO_CP, ST_AHI_RQ, ST_AHI_CP, ST_AOP_RQ, ST_AOP_CP,
      ST_WBACK,
      ST_CLO_RQ, ST_CLO_CP, ST_CHI_RQ, ST_CHI_CP, ST_JUMP,
      ST_SKIP1, ST_SKIP2
   } step_e;

   localparam int unsigned PTR_LANES = 2;

   typedef struct packed {
      logic                 rd;
      logic                 wr;
      logic                 addr_ptr;
      logic                 pc_inc;
      logic                 pc_load;
      logic [PTR_LANES-1:0] ptr_we;
      logic                 b_we;
      logic                 res_we;
      logic                 done;
   } ctrl_t;

endpackage

// File: rtl/negbr_sub.sv
module negbr_sub #(
   parameter int unsigned W     = 8,
   parameter int unsigned STYLE = 0
) (
   input  logic [W-1:0] minuend,
   input  logic [W-1:0] subtrahend,
   output logic [W-1:0] diff
);
   generate
      if (STYLE == 0) begin : g_behav
         assign diff = minuend - subtrahend;
      end else begin : g_ripple
         logic [W-1:0] brw;
         assign brw[0] = 1'b0;
         for (genvar g = 0; g < W; g++) begin : g_bit
            assign diff[g] = minuend[g] ^ subtrahend[g] ^ brw[g];
            if (g < W - 1) begin : g_chain
               assign brw[g+1] = (~minuend[g] & subtrahend[g]) |
                                 (~(minuend[g] ^ subtrahend[g]) & brw[g]);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/negbr_datapath.sv
module negbr_datapath
   import negbr_pkg::*;
#(
   parameter int unsigned          ADDR_W    = 16,
   parameter int unsigned          DATA_W    = 8,
   parameter int unsigned          SUB_STYLE = 0,
   parameter logic [ADDR_W-1:0]    RESET_PC  = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 addr_ptr,
   input  logic                 pc_inc,
   input  logic                 pc_load,
   input  logic [PTR_LANES-1:0] ptr_we,
   input  logic                 b_we,
   input  logic                 res_we,
   input  logic [DATA_W-1:0]    rdata,
   output logic [ADDR_W-1:0]    addr,
   output logic [DATA_W-1:0]    wdata,
   output logic [ADDR_W-1:0]    pc_o,
   output logic [ADDR_W-1:0]    ptr_o,
   output logic                 res_msb
);
   localparam int unsigned LANE_W = ADDR_W / PTR_LANES;

   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [DATA_W-1:0] b_q;
   logic [DATA_W-1:0] res_q;
   logic [DATA_W-1:0] diff;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q <= RESET_PC;
      end else if (pc_load) begin
         pc_q <= ptr_q;
      end else if (pc_inc) begin
         pc_q <= pc_q + 1'b1;
      end
   end

   generate
      for (genvar g = 0; g < PTR_LANES; g++) begin : g_lane
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ptr_q[g*LANE_W +: LANE_W] <= '0;
            end else if (ptr_we[g]) begin
               ptr_q[g*LANE_W +: LANE_W] <= rdata[LANE_W-1:0];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         b_q <= '0;
      end else if (b_we) begin
         b_q <= rdata;
      end
   end

   negbr_sub #(.W(DATA_W), .STYLE(SUB_STYLE)) u_sub (
      .minuend   (rdata),
      .subtrahend(b_q),
      .diff      (diff)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q <= '0;
      end else if (res_we) begin
         res_q <= diff;
      end
   end

   assign addr    = addr_ptr ? ptr_q : pc_q;
   assign wdata   = res_q;
   assign pc_o    = pc_q;
   assign ptr_o   = ptr_q;
   assign res_msb = res_q[DATA_W-1];
endmodule

// File: rtl/negbr_seq.sv
module negbr_seq
   import negbr_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  res_msb,
   output ctrl_t ctrl
);
   step_e st_q, st_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= ST_BLO_RQ;
      end else begin
         st_q <= st_d;
      end
   end

   always_comb begin
      ctrl = '0;
      st_d = st_q;
      case (st_q)
         ST_BLO_RQ: begin ctrl.rd = 1'b1; st_d = ST_BLO_CP; end
         ST_BLO_CP: begin ctrl.ptr_we = 2'b01; ctrl.pc_inc = 1'b1; st_d = ST_BHI_RQ; end
         ST_BHI_RQ: begin ctrl.rd = 1'b1; st_d = ST_BHI_CP; end
         ST_BHI_CP: begin ctrl.ptr_we = 2'b10; st_d = ST_BOP_RQ; end
         ST_BOP_RQ: begin ctrl.rd = 1'b1; ctrl.addr_ptr = 1'b1; st_d = ST_BOP_CP; end
         ST_BOP_CP: begin ctrl.b_we = 1'b1; ctrl.pc_inc = 1'b1; st_d = ST_ALO_RQ; end
         ST_ALO_RQ: begin ctrl.rd = 1'b1; st_d = ST_ALO_CP; end
         ST_ALO_CP: begin ctrl.ptr_we = 2'b01; ctrl.pc_inc = 1'b1; st_d = ST_AHI_RQ; end
         ST_AHI_RQ: begin ctrl.rd = 1'b1; st_d = ST_AHI_CP; end
         ST_AHI_CP: begin ctrl.ptr_we = 2'b10; st_d = ST_AOP_RQ; end
         ST_AOP_RQ: begin ctrl.rd = 1'b1; ctrl.addr_ptr = 1'b1; st_d = ST_AOP_CP; end
         ST_AOP_CP: begin ctrl.res_we = 1'b1; st_d = ST_WBACK; end
         ST_WBACK: begin
            ctrl.wr       = 1'b1;
            ctrl.addr_ptr = 1'b1;
            ctrl.pc_inc   = 1'b1;
            st_d          = res_msb ? ST_CLO_RQ : ST_SKIP1;
         end
         ST_CLO_RQ: begin ctrl.rd = 1'b1; st_d = ST_CLO_CP; end
         ST_CLO_CP: begin ctrl.ptr_we = 2'b01; ctrl.pc_inc = 1'b1; st_d = ST_CHI_RQ; end
         ST_CHI_RQ: begin ctrl.rd = 1'b1; st_d = ST_CHI_CP; end
         ST_CHI_CP: begin ctrl.ptr_we = 2'b10; st_d = ST_JUMP; end
         ST_JUMP:   begin ctrl.pc_load = 1'b1; ctrl.done = 1'b1; st_d = ST_BLO_RQ; end
         ST_SKIP1:  begin ctrl.pc_inc = 1'b1; st_d = ST_SKIP2; end
         ST_SKIP2:  begin ctrl.pc_inc = 1'b1; ctrl.done = 1'b1; st_d = ST_BLO_RQ; end
         default:   begin st_d = ST_BLO_RQ; end
      endcase
   end
endmodule

// File: rtl/negbranch_cpu.sv
module negbranch_cpu
   import negbr_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 16,
   parameter int unsigned       DATA_W    = 8,
   parameter int unsigned       SUB_STYLE = 0,
   parameter logic [ADDR_W-1:0] RESET_PC  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd_en,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_wr_en,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              instr_done,
   output logic [ADDR_W-1:0] pc
);
   generate
      if (ADDR_W != PTR_LANES * DATA_W) begin : g_bad_width
         $error("negbranch_cpu: ADDR_W must be twice DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("negbranch_cpu: DATA_W must be at least 2");
      end
      if (SUB_STYLE > 1) begin : g_bad_style
         $error("negbranch_cpu: SUB_STYLE must be 0 or 1");
      end
   endgenerate

   ctrl_t             ctrl;
   logic              res_msb_w;
   logic [ADDR_W-1:0] ptr_w;

   negbr_seq u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .res_msb(res_msb_w),
      .ctrl   (ctrl)
   );

   negbr_datapath #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .SUB_STYLE(SUB_STYLE),
      .RESET_PC (RESET_PC)
   ) u_dp (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_ptr(ctrl.addr_ptr),
      .pc_inc  (ctrl.pc_inc),
      .pc_load (ctrl.pc_load),
      .ptr_we  (ctrl.ptr_we),
      .b_we    (ctrl.b_we),
      .res_we  (ctrl.res_we),
      .rdata   (mem_rdata),
      .addr    (mem_addr),
      .wdata   (mem_wdata),
      .pc_o    (pc),
      .ptr_o   (ptr_w),
      .res_msb (res_msb_w)
   );

   assign mem_rd_en  = ctrl.rd;
   assign mem_wr_en  = ctrl.wr;
   assign instr_done = ctrl.done;
endmodule

// File: rtl/negbranch_chk.sv
module negbranch_chk #(
   parameter int unsigned ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd,
   input logic              wr,
   input logic              done,
   input logic [ADDR_W-1:0] pc,
   input logic [ADDR_W-1:0] ptr,
   input logic              res_msb
);
   logic [1:0] wr_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_seen <= '0;
      end else if (done) begin
         wr_seen <= '0;
      end else if (wr && wr_seen != 2'd3) begin
         wr_seen <= wr_seen + 2'd1;
      end
   end

   // R8
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd && wr));

   // R4
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> !wr);

   // R4
   wr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (wr_seen == 2'd1));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   neg_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && res_msb) |=> (pc == $past(ptr)));

   // R6
   pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !res_msb) |=> (pc == $past(pc) + 1'b1));
endmodule

bind negbranch_cpu negbranch_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .rd     (mem_rd_en),
   .wr     (mem_wr_en),
   .done   (instr_done),
   .pc     (pc),
   .ptr    (ptr_w),
   .res_msb(res_msb_w)
);

// File: tb/negbranch_cpu_bench.sv
`timescale 1ns/1ps
module negbranch_cpu_bench;
   localparam int NINSTR = 9;
   localparam int MSZ    = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] mem_addr;
   logic        mem_rd_en;
   logic [7:0]  mem_rdata = 8'h00;
   logic        mem_wr_en;
   logic [7:0]  mem_wdata;
   logic        instr_done;
   logic [15:0] pc;

   logic [7:0] mem  [0:MSZ-1];
   logic [7:0] refm [0:MSZ-1];

   logic [15:0] rdq[$];
   bit          rdk[$];
   logic [15:0] waq[$];
   logic [7:0]  wdq[$];
   logic [15:0] pcq[$];
   bit          negq[$];

   int  nchecks = 0;
   int  nerr = 0;
   int  n_done = 0;
   int  wr_cnt = 0;
   bit  active = 1'b0;
   bit  pend_pc = 1'b0;
   bit  timeout = 1'b0;
   logic [15:0] exp_pc;
   bit          exp_neg;

   always #5 clk = ~clk;

   negbranch_cpu u_negbranch_cpu (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_rd_en (mem_rd_en),
      .mem_rdata (mem_rdata),
      .mem_wr_en (mem_wr_en),
      .mem_wdata (mem_wdata),
      .instr_done(instr_done),
      .pc        (pc)
   );

   always @(posedge clk) begin
      if (mem_wr_en) mem[mem_addr[9:0]] <= mem_wdata;
      if (mem_rd_en) mem_rdata <= mem[mem_addr[9:0]];
   end

   function automatic int ix(logic [15:0] a);
      return int'(a[9:0]);
   endfunction

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      nchecks++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic put(logic [15:0] a, logic [7:0] v);
      mem[ix(a)]  = v;
      refm[ix(a)] = v;
   endtask

   task automatic put_instr(logic [15:0] at, logic [15:0] b, logic [15:0] a, logic [15:0] c);
      put(at,     b[7:0]); put(at + 1, b[15:8]);
      put(at + 2, a[7:0]); put(at + 3, a[15:8]);
      put(at + 4, c[7:0]); put(at + 5, c[15:8]);
   endtask

   // driver: reference model pushes expected strobes and next PC per instruction
   task automatic drive_expect(int k);
      logic [15:0] p;
      p = 16'h0000;
      for (int i = 0; i < k; i++) begin
         logic [15:0] bp, ap, cp;
         logic [7:0]  r;
         bp = {refm[ix(p + 1)], refm[ix(p)]};
         ap = {refm[ix(p + 3)], refm[ix(p + 2)]};
         rdq.push_back(p);     rdk.push_back(1'b0);
         rdq.push_back(p + 1); rdk.push_back(1'b0);
         rdq.push_back(bp);    rdk.push_back(1'b1);
         rdq.push_back(p + 2); rdk.push_back(1'b0);
         rdq.push_back(p + 3); rdk.push_back(1'b0);
         rdq.push_back(ap);    rdk.push_back(1'b1);
         r = refm[ix(ap)] - refm[ix(bp)];
         refm[ix(ap)] = r;
         waq.push_back(ap);
         wdq.push_back(r);
         if (r[7]) begin
            cp = {refm[ix(p + 5)], refm[ix(p + 4)]};
            rdq.push_back(p + 4); rdk.push_back(1'b0);
            rdq.push_back(p + 5); rdk.push_back(1'b0);
            p = cp;
            negq.push_back(1'b1);
         end else begin
            p = p + 16'd6;
            negq.push_back(1'b0);
         end
         pcq.push_back(p);
      end
   endtask

   // monitor: pops expectations as strobes and done pulses appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (pend_pc) begin
            pend_pc = 1'b0;
            chk(pc == exp_pc, exp_neg ? "R5" : "R6", "pc after instruction", pc, exp_pc);
            chk(!instr_done, "R7", "done pulse width", instr_done, 0);
            n_done++;
            if (n_done == NINSTR) active = 1'b0;
         end
         if (active) begin
            if (mem_rd_en) begin
               if (rdq.size() == 0) begin
                  chk(1'b0, "R9", "unexpected read", mem_addr, 0);
               end else begin
                  logic [15:0] ea;
                  bit          kind;
                  ea   = rdq.pop_front();
                  kind = rdk.pop_front();
                  chk(mem_addr == ea, kind ? "R2" : "R9", "read address", mem_addr, ea);
               end
            end
            if (mem_wr_en) begin
               chk(!mem_rd_en, "R8", "read during write", mem_rd_en, 0);
               if (waq.size() == 0) begin
                  chk(1'b0, "R4", "unexpected write", mem_addr, 0);
               end else begin
                  logic [15:0] wa;
                  logic [7:0]  wd;
                  wa = waq.pop_front();
                  wd = wdq.pop_front();
                  chk(mem_addr == wa, "R3", "write address", mem_addr, wa);
                  chk(mem_wdata == wd, "R3", "write data", mem_wdata, wd);
               end
               wr_cnt++;
            end
            if (instr_done) begin
               chk(wr_cnt == 1, "R4", "writes in instruction", wr_cnt, 1);
               wr_cnt = 0;
               if (pcq.size() == 0) begin
                  chk(1'b0, "R7", "unexpected done", 1, 0);
               end else begin
                  exp_pc  = pcq.pop_front();
                  exp_neg = negq.pop_front();
                  pend_pc = 1'b1;
               end
            end
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      timeout = 1'b1;
   end

   initial begin
      for (int i = 0; i < MSZ; i++) begin
         mem[i]  = 8'h00;
         refm[i] = 8'h00;
      end
      // data bytes
      put(16'h0040, 8'd10);  put(16'h0041, 8'd3);
      put(16'h0042, 8'd20);  put(16'h0043, 8'd5);
      put(16'h0044, 8'h55);  put(16'h0045, 8'h55);
      put(16'h0046, 8'h01);  put(16'h0047, 8'h80);
      put(16'h0048, 8'h00);  put(16'h0049, 8'h80);
      put(16'h004A, 8'h00);
      put(16'h0312, 8'h7F);  put(16'h0345, 8'h7E);
      // program: plain step, jump, zero, signed wrap, 0-1, high-byte pointers,
      // same location, borrow discarded, result exactly 0x80
      put_instr(16'h0000, 16'h0041, 16'h0040, 16'h0300);
      put_instr(16'h0006, 16'h0042, 16'h0043, 16'h0200);
      put_instr(16'h0200, 16'h0044, 16'h0045, 16'h0300);
      put_instr(16'h0206, 16'h0046, 16'h0047, 16'h0300);
      put_instr(16'h020C, 16'h0046, 16'h0048, 16'h0100);
      put_instr(16'h0100, 16'h0312, 16'h0345, 16'h0180);
      put_instr(16'h0180, 16'h0040, 16'h0040, 16'h0300);
      put_instr(16'h0186, 16'h0048, 16'h0041, 16'h0300);
      put_instr(16'h018C, 16'h0049, 16'h004A, 16'h03F0);
      drive_expect(NINSTR);

      repeat (3) @(negedge clk);
      // R1 reset state
      chk(pc == 16'h0000, "R1", "pc in reset", pc, 0);
      chk(!mem_wr_en, "R1", "write strobe in reset", mem_wr_en, 0);
      chk(mem_rd_en && mem_addr == 16'h0000, "R1", "first fetch address", mem_addr, 0);
      active = 1'b1;
      rst_n  = 1'b1;

      wait (n_done == NINSTR || timeout);
      if (timeout) chk(1'b0, "R7", "watchdog expired, done count", n_done, NINSTR);
      chk(rdq.size() == 0, "R9", "reads left unconsumed", rdq.size(), 0);
      chk(mem[ix(16'h0045)] == 8'h00, "R3", "zero result stored", mem[ix(16'h0045)], 0);
      chk(mem[ix(16'h0345)] == 8'hFF, "R3", "high-page result stored", mem[ix(16'h0345)], 8'hFF);
      $display("Result: errors=%0d of %0d checks", nerr, nchecks);
      $finish;
   end
endmodule